// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serializer Register

This block is an eight-stage register that either captures a byte in parallel and streams it out one bit at a time, or passes a serial stream through with an eight-step delay. The serial output is always the last stage. A debug view of all eight stages is also brought out. All logic runs on one free-running system clock. The register does not step on that clock directly. It steps on a rising edge of the OR of two clock-request inputs. While one request is held high, nothing steps. While one request is held low, the other one acts as the clock.

Both request inputs pass through two-flop synchronizers. A two-state edge machine then watches their OR. Its states are `EDGE_BLOCKED` (the last level seen was high) and `EDGE_ARMED` (the last level seen was low). It has three transitions:

- `EDGE_BLOCKED` to `EDGE_ARMED` when the level reads low.
- `EDGE_ARMED` to `EDGE_BLOCKED` when the level reads high. This transition emits a one-cycle step pulse.
- Otherwise the machine stays in its current state.

On each step pulse the register performs one of three named operations, chosen by the mode select:

- `OP_SHIFT`: mode high, shift one place.
- `OP_LOAD`: mode low, load all eight stages in parallel.
- `OP_HOLD`: no step pulse, keep every stage.

An asynchronous active-low wipe clears the stages at once. It also puts the synchronizers and the edge machine into the high/blocked condition.

Top module: `gated_piso_reg`

## Requirements
- R1: While `wipe_n` is low, all eight stages and `tail_out` are 0 at once, without waiting for a system clock edge.
- R2: On a step with `shift_mode` = 0, stage i takes `par_data[i]` for all i. Stage A is bit 0 and stage H is bit 7. No serial data enters.
- R3: On a step with `shift_mode` = 1, stage 0 takes `serial_in` and stage i takes the old stage i-1. The old stage 7 value is dropped.
- R4: With no step, every stage keeps its value whatever `shift_mode`, `serial_in` and `par_data` do.
- R5: A step occurs only on a low-to-high change of (`tick_a` OR `tick_b`). A rise of either input while the other is high gives no step, and a fall gives no step.
- R6: With one request input held low, a rising edge on the other one produces exactly one step. This holds whichever of the two is the active input.
- R7: `tail_out` always equals stage 7 (bit 7 of `stages_o`). After a parallel load, successive shifts present bit 7 first, then bit 6, and so on.
- R8: Releasing `wipe_n` while a request input is high produces no step.
- R9: A request rise applied just after system edge k changes the stages at edge k+3. The stages are unchanged after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| wipe_n | input | 1 | Asynchronous active-low clear |
| tick_a | input | 1 | Clock-request input, asynchronous |
| tick_b | input | 1 | Clock-request input, asynchronous |
| shift_mode | input | 1 | 1 = shift on step, 0 = parallel load on step |
| serial_in | input | 1 | Serial data entering stage 0 |
| par_data | input | 8 | Parallel data, bit i goes to stage i |
| tail_out | output | 1 | Serial output, stage 7 |
| stages_o | output | 8 | Debug view of all stages, bit i is stage i |

## Verification
A known byte is loaded in parallel and then shifted out. This separates a correct bit order on the output from a reversed or rotated one. A serial stream is clocked through the other request input. This shows that both inputs can serve as the clock and that the delay is exactly eight steps. Rises of one input while the other is high, falls, and data changes without any step tell a real edge detector apart from a level enable or a plain OR. A wipe in the middle of a stream, released while a request is high, exposes a false step after the clear. A cycle-exact sample around a single rise pins the three-cycle latency.

// File: rtl/gated_piso_pkg.sv
package gated_piso_pkg;
    typedef enum logic {
        EDGE_BLOCKED = 1'b0,
        EDGE_ARMED   = 1'b1
    } edge_state_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } reg_op_t;
endpackage

// File: rtl/gated_piso_sync.sv
module gated_piso_sync #(
    parameter int   WIDTH     = 2,
    parameter int   DEPTH     = 2,
    parameter logic RESET_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             wipe_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge wipe_n) begin
        if (!wipe_n) begin
            chain_q <= {DEPTH{{WIDTH{RESET_BIT}}}};
        end else begin
            chain_q[0] <= async_in;
            for (int d = 1; d < DEPTH; d++) begin
                chain_q[d] <= chain_q[d-1];
            end
        end
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/gated_piso_edge.sv
module gated_piso_edge
    import gated_piso_pkg::*;
(
    input  logic clk,
    input  logic wipe_n,
    input  logic level,
    output logic step
);
    edge_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge wipe_n) begin
        if (!wipe_n) state_q <= EDGE_BLOCKED;
        else         state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            EDGE_BLOCKED: if (!level) state_d = EDGE_ARMED;
            EDGE_ARMED: begin
                if (level) begin
                    state_d = EDGE_BLOCKED;
                    step    = 1'b1;
                end
            end
            default: state_d = EDGE_BLOCKED;
        endcase
    end

    // R5: a step never repeats on the next cycle
    p_single_step_r5: assert property (@(posedge clk) disable iff (!wipe_n)
        step |=> !step);

    // R5: a level that stays high produces no step
    p_no_step_steady_high_r5: assert property (@(posedge clk) disable iff (!wipe_n)
        (level && $past(level)) |-> !step);
endmodule

// File: rtl/gated_piso_core.sv
module gated_piso_core
    import gated_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             wipe_n,
    input  logic             step,
    input  logic             shift_mode,
    input  logic             serial_in,
    input  logic [WIDTH-1:0] par_data,
    output logic [WIDTH-1:0] bits
);
    reg_op_t op;

    always_comb begin
        if (!step)          op = OP_HOLD;
        else if (shift_mode) op = OP_SHIFT;
        else                 op = OP_LOAD;
    end

    always_ff @(posedge clk or negedge wipe_n) begin
        if (!wipe_n) begin
            bits <= '0;
        end else begin
            unique case (op)
                OP_SHIFT: bits <= {bits[WIDTH-2:0], serial_in};
                OP_LOAD:  bits <= par_data;
                default:  bits <= bits;
            endcase
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!wipe_n)
        !step |=> $stable(bits));

    p_load_r2: assert property (@(posedge clk) disable iff (!wipe_n)
        (step && !shift_mode) |=> (bits == $past(par_data)));

    p_shift_r3: assert property (@(posedge clk) disable iff (!wipe_n)
        (step && shift_mode) |=> (bits == {$past(bits[WIDTH-2:0]), $past(serial_in)}));
endmodule

// File: rtl/gated_piso_reg.sv
module gated_piso_reg #(
    parameter int WIDTH      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             wipe_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             shift_mode,
    input  logic             serial_in,
    input  logic [WIDTH-1:0] par_data,
    output logic             tail_out,
    output logic [WIDTH-1:0] stages_o
);
    localparam int REQS = 2;

    logic [REQS-1:0] req_sync;
    logic            req_level;
    logic            step;

    gated_piso_sync #(.WIDTH(REQS), .DEPTH(SYNC_DEPTH), .RESET_BIT(1'b1)) u_sync (
        .clk(clk), .wipe_n(wipe_n), .async_in({tick_b, tick_a}), .sync_out(req_sync)
    );

    assign req_level = |req_sync;

    gated_piso_edge u_edge (
        .clk(clk), .wipe_n(wipe_n), .level(req_level), .step(step)
    );

    gated_piso_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .wipe_n(wipe_n), .step(step), .shift_mode(shift_mode),
        .serial_in(serial_in), .par_data(par_data), .bits(stages_o)
    );

    assign tail_out = stages_o[WIDTH-1];

    // R8: first cycle out of wipe never steps
    p_no_step_after_wipe_r8: assert property (@(posedge clk) disable iff (!wipe_n)
        $rose(wipe_n) |-> !step);
endmodule

// File: tb/gated_piso_reg_tb.sv
module gated_piso_reg_tb_top;
    logic       clk = 1'b0;
    logic       wipe_n = 1'b0;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic       shift_mode = 1'b0;
    logic       serial_in = 1'b0;
    logic [7:0] par_data = 8'h00;
    logic       tail_out;
    logic [7:0] stages_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model;

    always #4 clk = ~clk;

    gated_piso_reg dut_i (
        .clk(clk), .wipe_n(wipe_n), .tick_a(tick_a), .tick_b(tick_b),
        .shift_mode(shift_mode), .serial_in(serial_in), .par_data(par_data),
        .tail_out(tail_out), .stages_o(stages_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // pulse one request input (0 = tick_a, 1 = tick_b)
    task automatic pulse(input int which);
        if (which == 0) tick_a = 1'b1; else tick_b = 1'b1;
        wait_neg(5);
        if (which == 0) tick_a = 1'b0; else tick_b = 1'b0;
        wait_neg(5);
    endtask

    task automatic step_model();
        if (shift_mode) model = {model[6:0], serial_in};
        else            model = par_data;
    endtask

    task automatic t_reset();
        chk("R1 reset stages", stages_o, 8'h00);
        chk("R1 reset tail", {7'd0, tail_out}, 8'h00);
        wipe_n = 1'b1;
        wait_neg(5);
        model = 8'h00;
        chk("R4 idle after release", stages_o, 8'h00);
    endtask

    task automatic t_load_and_shift();
        shift_mode = 1'b0;
        par_data   = 8'hB4;
        pulse(0);
        step_model();
        chk("R2 parallel load", stages_o, 8'hB4);
        chk("R7 tail after load", {7'd0, tail_out}, 8'h01);
        shift_mode = 1'b1;
        serial_in  = 1'b0;
        for (int k = 1; k < 8; k++) begin
            pulse(0);
            step_model();
            chk("R3 shift stages", stages_o, model);
            chk("R7 tail order", {7'd0, tail_out}, {7'd0, par_data[7-k]});
        end
    endtask

    task automatic t_serial_through();
        logic [15:0] stream = 16'b1100_1010_0111_0001;
        shift_mode = 1'b1;
        par_data   = 8'hFF;
        for (int k = 0; k < 16; k++) begin
            serial_in = stream[k];
            pulse(1);
            step_model();
            chk("R6 tick_b as clock", stages_o, model);
            if (k >= 7) chk("R3 eight-step delay", {7'd0, tail_out}, {7'd0, stream[k-7]});
        end
    endtask

    task automatic t_inhibit();
        logic [7:0] held;
        held = stages_o;
        tick_a = 1'b1;
        wait_neg(5);
        chk("R5 rise of tick_a gives one step", stages_o, {held[6:0], serial_in});
        step_model();
        held = stages_o;
        for (int k = 0; k < 3; k++) begin
            par_data   = 8'h5A ^ 8'(k);
            shift_mode = k[0];
            serial_in  = ~serial_in;
            tick_b = 1'b1; wait_neg(5);
            tick_b = 1'b0; wait_neg(5);
        end
        chk("R5 tick_b blocked while tick_a high", stages_o, held);
        tick_a = 1'b0;
        wait_neg(5);
        chk("R5 falling OR gives no step", stages_o, held);
        chk("R4 hold with data changing", stages_o, model);
        // unsafe case: tick_b rises while tick_a low -> a step
        shift_mode = 1'b0;
        par_data   = 8'h3C;
        tick_b = 1'b1; wait_neg(5);
        step_model();
        chk("R5 tick_b rise with tick_a low steps", stages_o, 8'h3C);
        tick_b = 1'b0; wait_neg(5);
    endtask

    task automatic t_latency();
        shift_mode = 1'b0;
        par_data   = 8'hE1;
        tick_a = 1'b1;
        wait_neg(2);
        chk("R9 unchanged two edges after rise", stages_o, model);
        wait_neg(1);
        step_model();
        chk("R9 updated third edge after rise", stages_o, 8'hE1);
        tick_a = 1'b0;
        wait_neg(5);
    endtask

    task automatic t_clear_mid_shift();
        shift_mode = 1'b1;
        serial_in  = 1'b1;
        pulse(0);
        step_model();
        chk("R3 shift before clear", stages_o, model);
        tick_a = 1'b1;
        @(posedge clk);
        #2;
        wipe_n = 1'b0;
        #1;
        chk("R1 async clear between edges", stages_o, 8'h00);
        model = 8'h00;
        wait_neg(2);
        wipe_n = 1'b1;
        wait_neg(6);
        chk("R8 no step after release with request high", stages_o, 8'h00);
        tick_a = 1'b0;
        wait_neg(5);
        chk("R8 fall after release gives no step", stages_o, 8'h00);
        pulse(0);
        step_model();
        chk("R6 steps again after clear", stages_o, 8'h01);
        chk("R7 tail tracks stage 7", {7'd0, tail_out}, {7'd0, stages_o[7]});
    endtask

    initial begin
        model = 8'h00;
        wait_neg(3);
        t_reset();
        t_load_and_shift();
        t_serial_through();
        t_inhibit();
        t_latency();
        t_clear_mid_shift();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule